// File: doc/BRIEF.md
# I2S Serial Audio Transmitter with Stream-ID Selection

This block converts stereo sample pairs from a valid/ready stream into an I2S serial link for an external DAC. It runs from a single master clock. Two integer dividers inside the block produce the serial bit clock and the word-select clock, so both stay phase-locked to the master clock and no second clock domain exists. All three pin outputs come from registers placed one master cycle behind the internal counters. This retiming gives the external converter margin against routing skew inside the fabric.

Each incoming beat carries a stream tag. The block plays a beat only when its tag equals the value on `listen_id`. Beats with any other tag still complete their handshake, so a shared stream carrying several tagged sources keeps moving. A beat with `s_tlast` low is a left sample. A beat with `s_tlast` high is the right sample and closes the pair. The block holds one complete pair in a holding register. At each frame boundary it moves that pair into the transmit frame and shifts it out MSB first. When no pair is waiting at a boundary, it sends a silent frame and raises a sticky underrun flag.

Top module: `i2s_tx`

## Requirements
- R1: `i2s_sck` has a period of MCLK_PER_SCK master cycles. It is low for the first MCLK_PER_SCK/2 of them and high for the rest.
- R2: `i2s_ws` is low for SCK_PER_WS/2 serial-clock periods (left channel), then high for the same count (right channel). It changes only in the master cycle where `i2s_sck` falls.
- R3: Within a frame, serial slot n carries data position n-1, wrapping so that slot 0 carries the last position of the previous frame. Positions 0 to SCK_PER_WS/2-1 belong to the left word and the rest to the right word. Each word starts with its MSB, one serial-clock period after `i2s_ws` changes. Positions at or beyond SAMPLE_W carry 0. `i2s_sd` changes only when `i2s_sck` falls.
- R4: The three pins are registered one master cycle behind the internal clock generation. `i2s_sck` first rises MCLK_PER_SCK/2+3 master rising edges after `rst_n` is released.
- R5: `s_tready` is high exactly when the holding register is empty and the block is out of reset. A held pair stays unchanged until the frame logic takes it.
- R6: A beat whose `s_tid` differs from `listen_id` completes its handshake but changes neither the stored samples nor the serial output.
- R7: A matching beat with `s_tlast`=0 stores a left sample. A matching beat with `s_tlast`=1 forms a pair from that right sample and the most recently stored left sample, which is zero if none has been stored since reset.
- R8: The held pair enters the transmit frame on the master edge that ends slot 0 of a frame, which is the same edge where `i2s_sck` falls into slot 1. That edge frees the holding register.
- R9: If the holding register is empty at that edge, the frame carries zeros in both channels and `underrun` goes high and stays high until reset.
- R10: While reset is asserted, all outputs are low. After `rst_n` rises, `s_tready` goes high after the second master edge, and the third edge is the first one that advances the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| listen_id | input | TID_W | Stream tag whose beats are played |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat ready (holding register free) |
| s_tdata | input | SAMPLE_W | Audio sample |
| s_tlast | input | 1 | High on the right-channel beat of a pair |
| s_tid | input | TID_W | Stream tag of the beat |
| i2s_sck | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select, low = left |
| i2s_sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky flag: a frame went out without a pair |

## Verification
The bench builds the block with SAMPLE_W=6, SCK_PER_WS=16 and MCLK_PER_SCK=6. The divider of 6 is not a power of two, which exercises the counter wrap. A frame takes only 96 master cycles, so many frame boundaries fit into a short run. With a 6-bit sample in an 8-slot half frame, every frame contains zero padding slots, and slot 0 carries padding from the previous frame. At this frame length, back-to-back feeding, tag mismatches, starvation into underrun and right-only pairs are all reachable.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  // Channel carried by a stream beat or a serial slot.
  typedef enum logic {
    SLOT_LEFT  = 1'b0,
    SLOT_RIGHT = 1'b1
  } chan_e;

endpackage

// File: rtl/i2s_tx_clkgen.sv
// Master-clock divider chain: bit-clock phase counter and frame slot counter.
module i2s_tx_clkgen #(
  parameter int MCLK_PER_SCK = 4,
  parameter int SCK_PER_WS   = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          tick,
  output logic                          sck_int,
  output logic                          ws_int,
  output logic [$clog2(SCK_PER_WS)-1:0] slot
);

  localparam int DIV_W  = $clog2(MCLK_PER_SCK);
  localparam int SLOT_W = $clog2(SCK_PER_WS);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(MCLK_PER_SCK - 1);
  localparam logic [DIV_W-1:0]  DIV_HALF  = DIV_W'(MCLK_PER_SCK / 2);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SCK_PER_WS - 1);
  localparam logic [SLOT_W-1:0] SLOT_HALF = SLOT_W'(SCK_PER_WS / 2);

  logic [DIV_W-1:0]  div_q, div_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  // tick marks the last master cycle of a bit period; the next edge is a falling sck
  always_comb begin
    tick   = (div_q == DIV_LAST);
    div_d  = tick ? '0 : div_q + 1'b1;
    slot_d = slot_q;
    if (tick) begin
      slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
    end else begin
      div_q <= div_d;
      if (tick) begin
        slot_q <= slot_d;
      end
    end
  end

  assign sck_int = (div_q >= DIV_HALF);
  assign ws_int  = (slot_q >= SLOT_HALF);
  assign slot    = slot_q;

  // Word select may only move on the edge that closes a bit period.
  assert_ws_moves_on_tick_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$stable(ws_int) |-> $past(tick)
  );

endmodule

// File: rtl/i2s_tx_pairbuf.sv
// Stream intake: tag filter, left capture, single stereo pair holding register.
module i2s_tx_pairbuf
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int TID_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_tvalid,
  output logic                s_tready,
  input  logic [SAMPLE_W-1:0] s_tdata,
  input  logic                s_tlast,
  input  logic [TID_W-1:0]    s_tid,
  input  logic [TID_W-1:0]    listen_id,
  input  logic                take,
  output logic                pair_valid,
  output logic [SAMPLE_W-1:0] pair_l,
  output logic [SAMPLE_W-1:0] pair_r
);

  logic                full_q, full_d;
  logic [SAMPLE_W-1:0] left_q;
  logic [SAMPLE_W-1:0] pair_l_q;
  logic [SAMPLE_W-1:0] pair_r_q;
  logic                accept;
  logic                hit;
  chan_e               kind;
  logic                left_en;
  logic                pair_en;

  assign s_tready = ~full_q & rst_n;

  always_comb begin
    accept  = s_tvalid & s_tready;
    hit     = accept && (s_tid == listen_id);
    kind    = s_tlast ? SLOT_RIGHT : SLOT_LEFT;
    left_en = hit && (kind == SLOT_LEFT);
    pair_en = hit && (kind == SLOT_RIGHT);
    full_d  = full_q;
    if (take) begin
      full_d = 1'b0;
    end
    if (pair_en) begin
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      left_q   <= '0;
      pair_l_q <= '0;
      pair_r_q <= '0;
    end else begin
      full_q <= full_d;
      if (left_en) begin
        left_q <= s_tdata;
      end
      if (pair_en) begin
        pair_l_q <= left_q;
        pair_r_q <= s_tdata;
      end
    end
  end

  assign pair_valid = full_q;
  assign pair_l     = pair_l_q;
  assign pair_r     = pair_r_q;

  // A waiting pair is neither lost nor altered until the frame logic takes it.
  assert_pair_held_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(pair_l_q) && $stable(pair_r_q))
  );

endmodule

// File: rtl/i2s_tx_serializer.sv
// Transmit frame register and slot-to-bit selection.
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int SCK_PER_WS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [$clog2(SCK_PER_WS)-1:0] slot,
  input  logic                          pair_valid,
  input  logic [SAMPLE_W-1:0]           pair_l,
  input  logic [SAMPLE_W-1:0]           pair_r,
  output logic                          take,
  output logic                          sd_int,
  output logic                          underrun
);

  localparam int SLOT_W = $clog2(SCK_PER_WS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SCK_PER_WS - 1);
  localparam logic [SLOT_W-1:0] SLOT_HALF = SLOT_W'(SCK_PER_WS / 2);

  logic                load;
  logic [SAMPLE_W-1:0] frame_l_q, frame_l_d;
  logic [SAMPLE_W-1:0] frame_r_q, frame_r_d;
  logic                under_q, under_d;
  logic [SLOT_W-1:0]   pos;
  logic [SLOT_W-1:0]   bit_ix;
  chan_e               ch;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] shifted;

  // Frame boundary: the edge closing slot 0, after the previous frame's last bit.
  always_comb begin
    load      = tick && (slot == '0);
    frame_l_d = pair_valid ? pair_l : '0;
    frame_r_d = pair_valid ? pair_r : '0;
    under_d   = under_q | ~pair_valid;
  end

  // Slot n carries data position n-1; position past the sample width shifts to 0.
  always_comb begin
    pos     = (slot == '0) ? SLOT_LAST : slot - 1'b1;
    ch      = (pos >= SLOT_HALF) ? SLOT_RIGHT : SLOT_LEFT;
    bit_ix  = (ch == SLOT_RIGHT) ? pos - SLOT_HALF : pos;
    word    = (ch == SLOT_RIGHT) ? frame_r_q : frame_l_q;
    shifted = word << bit_ix;
    sd_int  = shifted[SAMPLE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_l_q <= '0;
      frame_r_q <= '0;
      under_q   <= 1'b0;
    end else if (load) begin
      frame_l_q <= frame_l_d;
      frame_r_q <= frame_r_d;
      under_q   <= under_d;
    end
  end

  assign take     = load;
  assign underrun = under_q;

  assert_underrun_sticky_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    under_q |=> under_q
  );

  // Frame contents move only at the boundary edge.
  assert_frame_at_boundary_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!$stable(frame_l_q) || !$stable(frame_r_q)) |-> $past(load)
  );

endmodule

// File: rtl/i2s_tx.sv
// I2S transmitter top: reset synchronizer, clock divider, intake, serializer, pin retiming.
module i2s_tx #(
  parameter int SAMPLE_W     = 24,
  parameter int TID_W        = 4,
  parameter int MCLK_PER_SCK = 4,
  parameter int SCK_PER_WS   = 64
) (
  input  logic                clk_m,
  input  logic                rst_n,
  input  logic [TID_W-1:0]    listen_id,
  input  logic                s_tvalid,
  output logic                s_tready,
  input  logic [SAMPLE_W-1:0] s_tdata,
  input  logic                s_tlast,
  input  logic [TID_W-1:0]    s_tid,
  output logic                i2s_sck,
  output logic                i2s_ws,
  output logic                i2s_sd,
  output logic                underrun
);

  localparam int SLOT_W = $clog2(SCK_PER_WS);

  logic              rst_s1, rst_int;
  logic              tick, sck_int, ws_int, sd_int;
  logic [SLOT_W-1:0] slot;
  logic              take, pair_valid;
  logic [SAMPLE_W-1:0] pair_l, pair_r;
  logic              sck_q, ws_q, sd_q;

  // Asynchronous assertion, synchronous two-stage release.
  always_ff @(posedge clk_m or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_int <= rst_s1;
    end
  end

  i2s_tx_clkgen #(
    .MCLK_PER_SCK (MCLK_PER_SCK),
    .SCK_PER_WS   (SCK_PER_WS)
  ) u_clkgen (
    .clk     (clk_m),
    .rst_n   (rst_int),
    .tick    (tick),
    .sck_int (sck_int),
    .ws_int  (ws_int),
    .slot    (slot)
  );

  i2s_tx_pairbuf #(
    .SAMPLE_W (SAMPLE_W),
    .TID_W    (TID_W)
  ) u_pairbuf (
    .clk        (clk_m),
    .rst_n      (rst_int),
    .s_tvalid   (s_tvalid),
    .s_tready   (s_tready),
    .s_tdata    (s_tdata),
    .s_tlast    (s_tlast),
    .s_tid      (s_tid),
    .listen_id  (listen_id),
    .take       (take),
    .pair_valid (pair_valid),
    .pair_l     (pair_l),
    .pair_r     (pair_r)
  );

  i2s_tx_serializer #(
    .SAMPLE_W   (SAMPLE_W),
    .SCK_PER_WS (SCK_PER_WS)
  ) u_ser (
    .clk        (clk_m),
    .rst_n      (rst_int),
    .tick       (tick),
    .slot       (slot),
    .pair_valid (pair_valid),
    .pair_l     (pair_l),
    .pair_r     (pair_r),
    .take       (take),
    .sd_int     (sd_int),
    .underrun   (underrun)
  );

  // One master cycle of retiming on every pin keeps the three aligned with each other.
  always_ff @(posedge clk_m or negedge rst_int) begin
    if (!rst_int) begin
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
      sd_q  <= 1'b0;
    end else begin
      sck_q <= sck_int;
      ws_q  <= ws_int;
      sd_q  <= sd_int;
    end
  end

  assign i2s_sck = sck_q;
  assign i2s_ws  = ws_q;
  assign i2s_sd  = sd_q;

  assert_ws_on_sck_fall_R2: assert property (
    @(posedge clk_m) disable iff (!rst_int)
    !$stable(i2s_ws) |-> $fell(i2s_sck)
  );

  assert_sd_on_sck_fall_R3: assert property (
    @(posedge clk_m) disable iff (!rst_int)
    !$stable(i2s_sd) |-> $fell(i2s_sck)
  );

endmodule

// File: tb/i2s_tx_tb_top.sv
module i2s_tx_tb_top;

  localparam int SW  = 6;
  localparam int TW  = 4;
  localparam int MPS = 6;
  localparam int SPW = 16;
  localparam logic [TW-1:0] SEL = 4'h5;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tvalid;
  logic [SW-1:0] tdata;
  logic          tlast;
  logic [TW-1:0] tid;
  logic          tready, sck, ws, sd, und;

  always #5 clk = ~clk;

  i2s_tx #(
    .SAMPLE_W     (SW),
    .TID_W        (TW),
    .MCLK_PER_SCK (MPS),
    .SCK_PER_WS   (SPW)
  ) dut_i (
    .clk_m     (clk),
    .rst_n     (rst_n),
    .listen_id (SEL),
    .s_tvalid  (tvalid),
    .s_tready  (tready),
    .s_tdata   (tdata),
    .s_tlast   (tlast),
    .s_tid     (tid),
    .i2s_sck   (sck),
    .i2s_ws    (ws),
    .i2s_sd    (sd),
    .underrun  (und)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  int          k = 0;
  int          boot = 0;
  bit          m_full = 1'b0;
  logic [SW-1:0] m_left = '0, m_pl = '0, m_pr = '0, m_fl = '0, m_fr = '0;
  bit          m_under = 1'b0;
  bit          last_acc = 1'b0;
  string       scen = "R3";

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at t=%0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  function automatic logic ref_bit(int s, logic [SW-1:0] l, logic [SW-1:0] r);
    int p, j;
    p = (s + SPW - 1) % SPW;
    j = p % (SPW / 2);
    if (j >= SW) return 1'b0;
    return (p >= SPW / 2) ? r[SW-1-j] : l[SW-1-j];
  endfunction

  // One master cycle: observe the edge just taken, update the model, compare.
  task automatic step();
    int  d, s;
    bit  load, acc;
    logic e_sck, e_ws, e_sd;
    @(negedge clk);
    last_acc = 1'b0;
    if (!rst_n) begin
      check("R10 reset sck", sck, 1'b0);
      check("R10 reset ws", ws, 1'b0);
      check("R10 reset sd", sd, 1'b0);
      check("R10 reset underrun", und, 1'b0);
      check("R10 reset tready", tready, 1'b0);
      return;
    end
    if (boot < 2) begin
      boot++;
      check("R10 startup tready", tready, (boot == 2));
      check("R10 startup sck", sck, 1'b0);
      check("R10 startup sd", sd, 1'b0);
      return;
    end
    d     = k % MPS;
    s     = (k / MPS) % SPW;
    e_sck = (d >= MPS / 2);
    e_ws  = (s >= SPW / 2);
    e_sd  = ref_bit(s, m_fl, m_fr);
    load  = (d == MPS - 1) && (s == 0);
    acc   = tvalid && !m_full;
    if (load) begin
      if (m_full) begin
        m_fl = m_pl; m_fr = m_pr; m_full = 1'b0;
      end else begin
        m_fl = '0; m_fr = '0; m_under = 1'b1;
      end
    end
    if (acc && tid == SEL) begin
      if (!tlast) m_left = tdata;
      else begin
        m_pl = m_left; m_pr = tdata; m_full = 1'b1;
      end
    end
    last_acc = acc;
    k++;
    check("R1 R4 sck", sck, e_sck);
    check("R2 ws", ws, e_ws);
    check({scen, " sd"}, sd, e_sd);
    check("R9 underrun", und, m_under);
    check("R5 tready", tready, !m_full);
  endtask

  task automatic send(logic [SW-1:0] dv, logic lv, logic [TW-1:0] idv);
    tvalid = 1'b1; tdata = dv; tlast = lv; tid = idv;
    do step(); while (!last_acc);
    tvalid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tvalid = 1'b0; tdata = '0; tlast = 1'b0; tid = '0;
    repeat (4) step();
    rst_n = 1'b1;
    step(); step();
    // R7 R8: pairs fed back to back, loaded at each frame boundary
    scen = "R3 R7 R8";
    send(6'h2A, 1'b0, SEL); send(6'h15, 1'b1, SEL);
    send(6'h3F, 1'b0, SEL); send(6'h01, 1'b1, SEL);
    // R6: foreign tags consumed between real beats, must not reach the line
    scen = "R3 R6";
    send(6'h33, 1'b0, 4'h2); send(6'h24, 1'b0, SEL);
    send(6'h3E, 1'b1, 4'hA); send(6'h18, 1'b1, SEL);
    send(6'h07, 1'b0, SEL);  send(6'h3C, 1'b1, SEL);
    // R9: starve the block for several frames
    scen = "R3 R9";
    repeat (3 * MPS * SPW) step();
    // R7: right-only beat reuses the most recent left sample
    scen = "R3 R7";
    send(6'h11, 1'b1, SEL);
    send(6'h2D, 1'b1, SEL);
    repeat (3 * MPS * SPW) step();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule